// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles the control-flow outcome of one instruction per clock. It receives both source register values, the current program counter, an offset that is already sign-extended, a three-bit condition code and two jump flags. From these it decides whether control leaves the sequential path. It then gives the address of the next instruction and, for the two jump forms, the return address to write back.

Conditional branches compare the two register values in one of six ways. Equality and inequality are tested directly. Ordering is tested either with the operands read as two's-complement numbers or with them read as plain unsigned magnitudes. A taken branch or a direct jump goes to the counter plus the offset. A register-indirect jump goes to the first register plus the offset, with the lowest address bit cleared.

Every result is registered. An instruction presented with `in_valid` high has its outcome on the outputs one clock later, so the unit fits as one stage of an execute pipeline.

Top module: `brj_unit`

## Requirements
- R1: With `is_branch` set and `br_cond` = 0 the branch is taken exactly when `rs1_val` equals `rs2_val`. With `br_cond` = 1 it is taken exactly when they differ.
- R2: With `br_cond` = 4 the branch is taken when `rs1_val` is less than `rs2_val` as two's-complement numbers. With `br_cond` = 5 it is taken when `rs1_val` is greater than or equal to `rs2_val` in the same sense.
- R3: With `br_cond` = 6 the branch is taken when `rs1_val` is less than `rs2_val` as unsigned numbers. With `br_cond` = 7 it is taken when `rs1_val` is greater than or equal to `rs2_val` as unsigned numbers.
- R4: A branch with `br_cond` equal to 2 or 3 is never taken.
- R5: A taken conditional branch gives `next_pc` = `pc_in` + `offset`, modulo 2^64.
- R6: When no jump is requested and no branch is taken, `next_pc` = `pc_in` + 4, `taken` is 0 and `link_we` is 0.
- R7: With `is_jal` set, `taken` and `link_we` are 1, `next_pc` = `pc_in` + `offset` and `link_val` = `pc_in` + 4.
- R8: With `is_jalr` set, `taken` and `link_we` are 1, `next_pc` = (`rs1_val` + `offset`) with bit 0 forced to 0, and `link_val` = `pc_in` + 4.
- R9: When several kinds are flagged at once, `is_jalr` wins over `is_jal`, and `is_jal` wins over `is_branch`.
- R10: `target_misaligned` is 1 exactly when `taken` is 1 and bit 1 or bit 0 of `next_pc` is 1.
- R11: Results appear one clock after the inputs are sampled with `in_valid` high, with `out_valid` = 1. After a cycle with `in_valid` low, all other outputs are 0.
- R12: While `rst` is high, and on the clock after it, `out_valid` and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| is_branch | input | 1 | Instruction is a conditional branch |
| is_jal | input | 1 | Instruction is a counter-relative jump with link |
| is_jalr | input | 1 | Instruction is a register-indirect jump with link |
| br_cond | input | 3 | Branch condition code (0 eq, 1 ne, 4 lt, 5 ge, 6 ltu, 7 geu) |
| rs1_val | input | 64 | First source register value |
| rs2_val | input | 64 | Second source register value |
| pc_in | input | 64 | Address of the current instruction |
| offset | input | 64 | Sign-extended immediate offset |
| out_valid | output | 1 | Registered outputs hold a result |
| taken | output | 1 | Control leaves the sequential path |
| next_pc | output | 64 | Address of the next instruction |
| link_val | output | 64 | Return address for the jump forms |
| link_we | output | 1 | `link_val` is to be written back |
| target_misaligned | output | 1 | A taken target is not on a 4-byte boundary |

## Verification
Every output of this unit is due exactly one rising edge after its inputs are sampled. Nothing lies between the input sample and the output register. The bench applies a new instruction at each falling edge. At the same point it computes the expected outcome from its own behavioural model and appends it to a queue. At the next falling edge it pops that entry and compares it with the outputs, so each comparison sits half a period after the edge that loaded the result. A reset cycle or an idle cycle pushes an all-zero entry, which keeps the queue aligned with the one-cycle latency.

// File: rtl/brj_pkg.sv
package brj_pkg;

    localparam int XLEN       = 64;
    localparam int INSN_BYTES = 4;

    typedef logic [XLEN-1:0] word_t;

    // Branch condition codes; the numeric values are decoded by this unit.
    typedef enum logic [2:0] {
        COND_EQ  = 3'd0,
        COND_NE  = 3'd1,
        COND_LT  = 3'd4,
        COND_GE  = 3'd5,
        COND_LTU = 3'd6,
        COND_GEU = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        SEL_SEQ   = 2'd0,
        SEL_PCREL = 2'd1,
        SEL_REG   = 2'd2
    } tgt_sel_e;

    typedef struct packed {
        logic same;
        logic below_s;
        logic below_u;
    } cmp_flags_t;

    typedef struct packed {
        logic  is_branch;
        logic  is_jal;
        logic  is_jalr;
        cond_e cond;
    } ctl_t;

    typedef struct packed {
        word_t seq;
        word_t pc_rel;
        word_t reg_ind;
    } targets_t;

    typedef struct packed {
        logic  taken;
        word_t next_pc;
        word_t link;
        logic  link_we;
        logic  misaligned;
    } result_t;

    function automatic logic cond_met(input cond_e c, input cmp_flags_t f);
        logic r;
        case (c)
            COND_EQ:  r = f.same;
            COND_NE:  r = !f.same;
            COND_LT:  r = f.below_s;
            COND_GE:  r = !f.below_s;
            COND_LTU: r = f.below_u;
            COND_GEU: r = !f.below_u;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic off_grid(input word_t a);
        word_t m;
        m = word_t'(INSN_BYTES - 1);
        return |(a & m);
    endfunction

endpackage

// File: rtl/brj_compare.sv
module brj_compare
    import brj_pkg::*;
#(
    parameter int W          = XLEN,
    parameter bit SHARED_CMP = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    localparam int MSB = W - 1;

    logic eq_w;
    logic ltu_w;
    logic lts_w;

    assign eq_w  = (a == b);
    assign ltu_w = (a < b);

    generate
        if (SHARED_CMP) begin : g_shared
            // Signed order reuses the unsigned comparator: if the signs
            // differ, the negative operand is the smaller one.
            logic sign_diff;
            assign sign_diff = a[MSB] ^ b[MSB];
            assign lts_w     = sign_diff ? a[MSB] : ltu_w;
        end else begin : g_split
            assign lts_w = ($signed(a) < $signed(b));
        end
    endgenerate

    always_comb begin
        flags         = '0;
        flags.same    = eq_w;
        flags.below_s = lts_w;
        flags.below_u = ltu_w;
    end

endmodule

// File: rtl/brj_targets.sv
module brj_targets
    import brj_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int STEP = INSN_BYTES
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base,
    input  logic [W-1:0] imm,
    output targets_t     tg
);
    localparam logic [W-1:0] STEP_W   = W'(STEP);
    localparam logic [W-1:0] LSB_MASK = ~W'(1);

    logic [W-1:0] seq_w;
    logic [W-1:0] rel_w;
    logic [W-1:0] ind_sum;

    assign seq_w   = pc + STEP_W;
    assign rel_w   = pc + imm;
    assign ind_sum = base + imm;

    always_comb begin
        tg         = '0;
        tg.seq     = seq_w;
        tg.pc_rel  = rel_w;
        tg.reg_ind = ind_sum & LSB_MASK;
    end

endmodule

// File: rtl/brj_decide.sv
module brj_decide
    import brj_pkg::*;
(
    input  ctl_t       ctl,
    input  cmp_flags_t flags,
    output tgt_sel_e   sel,
    output logic       take,
    output logic       link_en
);
    logic hit;

    assign hit = cond_met(ctl.cond, flags);

    // Fixed priority: register-indirect jump, then direct jump, then branch.
    always_comb begin
        sel     = SEL_SEQ;
        take    = 1'b0;
        link_en = 1'b0;
        if (ctl.is_jalr) begin
            sel     = SEL_REG;
            take    = 1'b1;
            link_en = 1'b1;
        end else if (ctl.is_jal) begin
            sel     = SEL_PCREL;
            take    = 1'b1;
            link_en = 1'b1;
        end else if (ctl.is_branch && hit) begin
            sel     = SEL_PCREL;
            take    = 1'b1;
        end
    end

endmodule

// File: rtl/brj_unit.sv
module brj_unit
    import brj_pkg::*;
#(
    parameter bit SHARED_CMP = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            is_branch,
    input  logic            is_jal,
    input  logic            is_jalr,
    input  logic [2:0]      br_cond,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] offset,
    output logic            out_valid,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link_val,
    output logic            link_we,
    output logic            target_misaligned
);
    localparam logic [XLEN-1:0] STEP_W = XLEN'(INSN_BYTES);

    ctl_t       ctl;
    cmp_flags_t flags;
    targets_t   tg;
    tgt_sel_e   sel;
    logic       take_d;
    logic       link_d;
    result_t    res_d;
    result_t    res_q;
    logic       vld_q;

    always_comb begin
        ctl           = '0;
        ctl.is_branch = is_branch;
        ctl.is_jal    = is_jal;
        ctl.is_jalr   = is_jalr;
        ctl.cond      = cond_e'(br_cond);
    end

    brj_compare #(.W(XLEN), .SHARED_CMP(SHARED_CMP)) u_cmp (
        .a     (rs1_val),
        .b     (rs2_val),
        .flags (flags)
    );

    brj_targets #(.W(XLEN), .STEP(INSN_BYTES)) u_tgt (
        .pc   (pc_in),
        .base (rs1_val),
        .imm  (offset),
        .tg   (tg)
    );

    brj_decide u_dec (
        .ctl     (ctl),
        .flags   (flags),
        .sel     (sel),
        .take    (take_d),
        .link_en (link_d)
    );

    always_comb begin
        res_d         = '0;
        res_d.taken   = take_d;
        res_d.link_we = link_d;
        res_d.link    = tg.seq;
        case (sel)
            SEL_PCREL: res_d.next_pc = tg.pc_rel;
            SEL_REG:   res_d.next_pc = tg.reg_ind;
            default:   res_d.next_pc = tg.seq;
        endcase
        res_d.misaligned = take_d && off_grid(res_d.next_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? res_d : '0;
        end
    end

    assign out_valid         = vld_q;
    assign taken             = res_q.taken;
    assign next_pc           = res_q.next_pc;
    assign link_val          = res_q.link;
    assign link_we           = res_q.link_we;
    assign target_misaligned = res_q.misaligned;

    // Equality branch outcome follows the sampled operands.
    p_eq_outcome_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(is_branch && !is_jal && !is_jalr && br_cond == 3'd0))
        |-> (taken == ($past(rs1_val) == $past(rs2_val))));

    // Not-taken results fall through to the next sequential address.
    p_fallthrough_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !taken) |-> (next_pc == $past(pc_in) + STEP_W));

    // Link value is always the return address of the sampled instruction.
    p_link_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && link_we) |-> (link_val == $past(pc_in) + STEP_W));

    // Register-indirect jumps never produce an odd target.
    p_ind_lsb_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(is_jalr)) |-> (taken && !next_pc[0]));

    // Only jump forms ask for a write-back.
    p_link_only_jump_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(!is_jal && !is_jalr)) |-> !link_we);

    // Misalignment is reported only for taken targets.
    p_mis_taken_r10: assert property (@(posedge clk) disable iff (rst)
        target_misaligned |-> (taken && out_valid));

    // Idle cycles leave every flag low.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!taken && !link_we && !target_misaligned && next_pc == '0));

    // The cycle after reset shows no result.
    p_reset_clear_r12: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !taken));

endmodule

// File: tb/brj_unit_test.sv
module brj_unit_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        is_branch = 1'b0;
    logic        is_jal = 1'b0;
    logic        is_jalr = 1'b0;
    logic [2:0]  br_cond = 3'd0;
    logic [63:0] rs1_val = '0;
    logic [63:0] rs2_val = '0;
    logic [63:0] pc_in = '0;
    logic [63:0] offset = '0;
    logic        out_valid;
    logic        taken;
    logic [63:0] next_pc;
    logic [63:0] link_val;
    logic        link_we;
    logic        target_misaligned;

    typedef struct {
        logic        v;
        logic        tk;
        logic [63:0] npc;
        logic [63:0] lnk;
        logic        lwe;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t queue_q[$];
    int   n_checks = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    brj_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .is_branch(is_branch), .is_jal(is_jal), .is_jalr(is_jalr),
        .br_cond(br_cond), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .pc_in(pc_in), .offset(offset),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .link_val(link_val), .link_we(link_we),
        .target_misaligned(target_misaligned)
    );

    function automatic exp_t model(input logic v, input logic br, input logic j,
                                   input logic jr, input logic [2:0] c,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic [63:0] pc, input logic [63:0] im,
                                   input logic in_rst);
        exp_t e;
        logic hit;
        e.v = 0; e.tk = 0; e.npc = 0; e.lnk = 0; e.lwe = 0; e.mis = 0;
        e.tag = (in_rst) ? "R12" : "R11";
        if (in_rst || !v) return e;
        e.v   = 1;
        e.lnk = pc + 64'd4;
        if (jr) begin
            e.tk = 1; e.lwe = 1; e.npc = (a + im) & ~64'd1; e.tag = (j || br) ? "R9" : "R8";
        end else if (j) begin
            e.tk = 1; e.lwe = 1; e.npc = pc + im; e.tag = br ? "R9" : "R7";
        end else if (br) begin
            hit = 0;
            case (c)
                3'd0: begin hit = (a == b); e.tag = "R1"; end
                3'd1: begin hit = (a != b); e.tag = "R1"; end
                3'd4: begin hit = ($signed(a) < $signed(b)); e.tag = "R2"; end
                3'd5: begin hit = ($signed(a) >= $signed(b)); e.tag = "R2"; end
                3'd6: begin hit = (a < b); e.tag = "R3"; end
                3'd7: begin hit = (a >= b); e.tag = "R3"; end
                default: begin hit = 0; e.tag = "R4"; end
            endcase
            e.tk  = hit;
            e.npc = hit ? pc + im : pc + 64'd4;
            if (hit) e.tag = {e.tag, "/R5"};
        end else begin
            e.npc = pc + 64'd4; e.tag = "R6";
        end
        e.mis = e.tk && (e.npc[1:0] != 2'b00);
        return e;
    endfunction

    task automatic chk(input string tag, input string nm, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (queue_q.size() == 0) return;
        e = queue_q.pop_front();
        chk({e.tag, "/R11"}, "out_valid", 64'(out_valid), 64'(e.v));
        chk(e.tag, "taken", 64'(taken), 64'(e.tk));
        chk(e.tag, "next_pc", next_pc, e.npc);
        chk({e.tag, "/R7"}, "link_val", link_val, e.lnk);
        chk(e.tag, "link_we", 64'(link_we), 64'(e.lwe));
        chk({e.tag, "/R10"}, "target_misaligned", 64'(target_misaligned), 64'(e.mis));
    endtask

    // One cycle: check the previous result, then drive the next instruction.
    task automatic step(input logic v, input logic br, input logic j, input logic jr,
                        input logic [2:0] c, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] pc, input logic [63:0] im);
        @(negedge clk);
        compare_out();
        in_valid = v; is_branch = br; is_jal = j; is_jalr = jr; br_cond = c;
        rs1_val = a; rs2_val = b; pc_in = pc; offset = im;
        queue_q.push_back(model(v, br, j, jr, c, a, b, pc, im, rst));
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] neg1 = 64'hFFFF_FFFF_FFFF_FFFF;
        logic [63:0] pc0  = 64'h0000_0000_8000_1000;
        // R12: reset holds everything at zero, even with a valid jump applied
        step(1, 0, 1, 0, 3'd0, 64'd1, 64'd2, pc0, 64'd16);
        step(1, 0, 1, 0, 3'd0, 64'd1, 64'd2, pc0, 64'd16);
        @(negedge clk); compare_out(); rst = 0;
        in_valid = 0;
        queue_q.push_back(model(0, 0, 0, 0, 0, 0, 0, 0, 0, 1)); // R12: clock after reset
        // R1 equality and inequality, both outcomes
        step(1, 1, 0, 0, 3'd0, 64'd5, 64'd5, pc0, 64'd64);
        step(1, 1, 0, 0, 3'd0, 64'd5, 64'd6, pc0, 64'd64);
        step(1, 1, 0, 0, 3'd1, 64'd5, 64'd6, pc0, neg1 - 64'd7);  // R5 negative offset
        step(1, 1, 0, 0, 3'd1, 64'd9, 64'd9, pc0, 64'd64);
        // R2 signed order: -1 < 1 signed
        step(1, 1, 0, 0, 3'd4, neg1, 64'd1, pc0, 64'd32);
        step(1, 1, 0, 0, 3'd5, neg1, 64'd1, pc0, 64'd32);
        step(1, 1, 0, 0, 3'd5, 64'd7, 64'd7, pc0, 64'd32);
        // R3 unsigned order: 0xFF..F is the largest
        step(1, 1, 0, 0, 3'd6, neg1, 64'd1, pc0, 64'd32);
        step(1, 1, 0, 0, 3'd7, neg1, 64'd1, pc0, 64'd32);
        step(1, 1, 0, 0, 3'd6, 64'd3, 64'd4, pc0, 64'd32);
        // R4 reserved codes never taken
        step(1, 1, 0, 0, 3'd2, 64'd5, 64'd5, pc0, 64'd32);
        step(1, 1, 0, 0, 3'd3, 64'd1, 64'd9, pc0, 64'd32);
        // R6 plain instruction and R11 idle cycle
        step(1, 0, 0, 0, 3'd0, 64'd5, 64'd5, pc0, 64'd32);
        step(0, 1, 1, 1, 3'd0, 64'd5, 64'd5, pc0, 64'd32);
        // R7 direct jump, R8 indirect jump with odd sum
        step(1, 0, 1, 0, 3'd0, 64'd0, 64'd0, pc0, 64'h100);
        step(1, 0, 0, 1, 3'd0, 64'h2001, 64'd0, pc0, 64'h10);
        // R9 priority
        step(1, 1, 1, 1, 3'd0, 64'h3000, 64'h3000, pc0, 64'h8);
        step(1, 1, 1, 0, 3'd1, 64'h3000, 64'h3000, pc0, 64'h8);
        // R10 misaligned targets, and an untaken branch to a misaligned place
        step(1, 0, 1, 0, 3'd0, 64'd0, 64'd0, pc0, 64'd2);
        step(1, 0, 0, 1, 3'd0, 64'h4003, 64'd0, pc0, 64'd0);
        step(1, 1, 0, 0, 3'd0, 64'd1, 64'd2, pc0, 64'd2);
        // R5 wrap-around of the target adder
        step(1, 1, 0, 0, 3'd7, 64'd9, 64'd2, neg1 - 64'd3, 64'd8);
        // Mixed patterns for all requirements
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
            if ($urandom % 3 == 0) b[63] = ~a[63];
            step($urandom % 8 != 0, $urandom % 2 == 1, $urandom % 6 == 0,
                 $urandom % 7 == 0, 3'($urandom), a, b,
                 {$urandom, $urandom} & ~64'd3, 64'($signed({$urandom % 4096}) - 2048));
        end
        step(0, 0, 0, 0, 3'd0, 0, 0, 0, 0);
        @(negedge clk); compare_out();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule